// File: doc/BRIEF.md
# Resolver Converter Sample Readout Controller

This controller sits on the host side of a resolver-to-digital converter and performs one complete reading per request. For an angle or speed reading it pulls the converter's sample strobe low, sets the two mode-select pins to the wanted channel and waits for the conversion to settle. It then fetches a 16-bit word as two bytes through an external SPI byte master, which runs in SPI mode 3. It raises the strobe again and keeps the strobe high for a recovery interval. Only after that interval does it deliver the right-aligned result.

Alignment follows the resolution setting (10, 12, 14 or 16 bits). An angle word is shifted down only when hysteresis is enabled. A speed word is always shifted down and sign-extended. A third request kind clears the converter's latched faults. It pulses the strobe, reads the fault byte through a configuration-mode access, and then pulses the strobe a second time. The controller also drives the resolution code onto the converter's two resolution pins.

All waits are counted in system clock cycles. The parameter `CONV_CLK_CYC` gives one converter clock period in system cycles, and `GUARD_CYC` covers the fixed 20 ns margin.

Top module: `rdc_sample_ctrl`

## Requirements
- R1: After reset and whenever idle, `sample_pin` is high, `req_ready` is high and `rslt_valid` is low. Right after reset, `mode_pins` shows configuration mode `2'b01`.
- R2: `req_kind` 0 requests angle and 1 requests speed. On acceptance, `sample_pin` goes low and `mode_pins` becomes `2'b00` (angle) or `2'b10` (speed). Bit 0 is the first mode pin. `sample_pin` stays low for at least 6*CONV_CLK_CYC+GUARD_CYC cycles before the first `spi_start`.
- R3: An angle or speed reading issues exactly two SPI bytes, each with `spi_tx`=0x00. The first received byte is the most significant. `spi_last` is 0 on the first byte and 1 on the second.
- R4: For an angle reading with `hyst_en`=1, the result is the word shifted right by 16 minus the resolution. With `hyst_en`=0, the word is returned unchanged.
- R5: For a speed reading, the result is the word shifted right by 16 minus the resolution and sign-extended from the resolution width to 16 bits.
- R6: After the last byte, `sample_pin` returns high. `rslt_valid` is not raised until `sample_pin` has been high for at least 2*CONV_CLK_CYC+GUARD_CYC cycles, so the next access cannot come earlier.
- R7: `req_kind` 2 clears faults, with `mode_pins`=`2'b01`. `sample_pin` goes low for at least the recovery interval and then high. Two bytes, each with `spi_tx`=0xFF and `spi_last`=1, are transferred. A second low pulse then follows. The result has the second received byte in bits 7:0, zeros above it, and `rslt_err`=0.
- R8: `res_sel` codes 0..3 select 10, 12, 14 and 16 bits. `res_pins[0]` carries code bit 1 and `res_pins[1]` carries code bit 0. The pins follow `res_sel` while idle and hold during a transaction.
- R9: `req_kind` 3 is unsupported. It completes in the cycle after acceptance with `rslt_valid`=1, `rslt_err`=1 and data 0. `sample_pin` is not lowered and no SPI byte is issued.
- R10: `req_valid` while busy is ignored. `res_sel` and `hyst_en` are sampled only at acceptance.
- R11: `req_ready` is high in the cycle `rslt_valid` is strobed, and a request presented in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_kind | input | 2 | 0 angle, 1 speed, 2 fault clear, 3 unsupported |
| req_ready | output | 1 | Controller idle and able to accept |
| res_sel | input | 2 | Resolution code (10 + 2*code bits) |
| hyst_en | input | 1 | Hysteresis enabled in the converter |
| spi_start | output | 1 | One-cycle request to the SPI byte master |
| spi_tx | output | 8 | Byte to shift out |
| spi_last | output | 1 | Release chip select after this byte |
| spi_done | input | 1 | Byte master finished, spi_rx valid |
| spi_rx | input | 8 | Byte received |
| sample_pin | output | 1 | Converter sample strobe (idle high) |
| mode_pins | output | 2 | Converter mode select, bit 0 first pin |
| res_pins | output | 2 | Converter resolution pins |
| rslt_valid | output | 1 | One result available this cycle |
| rslt_err | output | 1 | Result belongs to an unsupported request |
| rslt_data | output | 16 | Aligned result |

## Verification
Result delivery and request acceptance can share one cycle. The bench provokes this by presenting a fault-clear request in exactly the cycle the speed result is strobed. It checks that `req_ready` is high there and that both results are correct. It also checks that the second transaction's strobe timing still honours the recovery interval. A second overlap comes from changing `res_sel`, `hyst_en` and `req_kind` while a reading is in flight. That result must reflect only the settings taken at acceptance, and the resolution pins must not move.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [1:0] {
        REQ_ANGLE = 2'd0,
        REQ_SPEED = 2'd1,
        REQ_FAULT = 2'd2,
        REQ_BAD   = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_XFER,
        PH_PULSE,
        PH_GUARD
    } phase_e;

    // {second pin, first pin}
    localparam logic [1:0] MODE_ANGLE = 2'b00;
    localparam logic [1:0] MODE_SPEED = 2'b10;
    localparam logic [1:0] MODE_CFG   = 2'b01;

    localparam logic [7:0] FAULT_ADDR  = 8'hFF;
    localparam logic [7:0] FAULT_DUMMY = 8'hFF;
    localparam logic [7:0] READ_FILL   = 8'h00;

    localparam int RES_MIN = 10;

endpackage

// File: rtl/rdc_wait_timer.sv
module rdc_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/rdc_word_align.sv
module rdc_word_align
    import rdc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] word,
    input  req_kind_e         kind,
    input  logic [1:0]        res_code,
    input  logic              hyst,
    output logic [WORD_W-1:0] data_o
);

    localparam int MAX_SHIFT = WORD_W - RES_MIN;
    localparam int SH_W      = $clog2(MAX_SHIFT + 1);

    logic [SH_W-1:0]          shamt;
    logic signed [WORD_W-1:0] sword;

    always_comb begin
        shamt = SH_W'(MAX_SHIFT) - SH_W'({res_code, 1'b0});
        sword = $signed(word);
        case (kind)
            REQ_ANGLE: data_o = hyst ? (word >> shamt) : word;
            REQ_SPEED: data_o = WORD_W'(sword >>> shamt);
            REQ_FAULT: data_o = {{(WORD_W-8){1'b0}}, word[7:0]};
            default:   data_o = '0;
        endcase
    end

endmodule

// File: rtl/rdc_sample_ctrl.sv
module rdc_sample_ctrl
    import rdc_pkg::*;
#(
    parameter int CONV_CLK_CYC = 4,
    parameter int GUARD_CYC    = 2,
    parameter int WORD_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    output logic              req_ready,
    input  logic [1:0]        res_sel,
    input  logic              hyst_en,
    output logic              spi_start,
    output logic [7:0]        spi_tx,
    output logic              spi_last,
    input  logic              spi_done,
    input  logic [7:0]        spi_rx,
    output logic              sample_pin,
    output logic [1:0]        mode_pins,
    output logic [1:0]        res_pins,
    output logic              rslt_valid,
    output logic              rslt_err,
    output logic [WORD_W-1:0] rslt_data
);

    localparam int SETTLE_CYC  = 6 * CONV_CLK_CYC + GUARD_CYC;
    localparam int RECOVER_CYC = 2 * CONV_CLK_CYC + GUARD_CYC;
    localparam int TMR_W       = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        req_kind_e         kind;
        logic [1:0]        res;
        logic              hyst;
        logic              second;
        logic [7:0]        hi_byte;
        logic [WORD_W-1:0] word;
        logic              sample;
        logic [1:0]        mode;
        logic [1:0]        rpins;
        logic              start;
        logic [7:0]        tx;
        logic              last;
        logic              vld;
        logic              err;
        logic [WORD_W-1:0] data;
    } ctl_t;

    ctl_t              s_d, s_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [WORD_W-1:0] aligned;
    req_kind_e         new_kind;

    rdc_wait_timer #(
        .CNT_W (TMR_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    rdc_word_align #(
        .WORD_W (WORD_W)
    ) i_align (
        .word     (s_q.word),
        .kind     (s_q.kind),
        .res_code (s_q.res),
        .hyst     (s_q.hyst),
        .data_o   (aligned)
    );

    assign new_kind = req_kind_e'(req_kind);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.vld   = 1'b0;
        s_d.err   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;

        case (s_q.phase)
            PH_IDLE: begin
                // resolution pins track the setting only between transactions
                s_d.rpins = {res_sel[0], res_sel[1]};
                if (req_valid) begin
                    s_d.kind   = new_kind;
                    s_d.res    = res_sel;
                    s_d.hyst   = hyst_en;
                    s_d.second = 1'b0;
                    case (new_kind)
                        REQ_ANGLE, REQ_SPEED: begin
                            s_d.sample = 1'b0;
                            s_d.mode   = (new_kind == REQ_ANGLE) ? MODE_ANGLE : MODE_SPEED;
                            tmr_load   = 1'b1;
                            tmr_val    = TMR_W'(SETTLE_CYC);
                            s_d.phase  = PH_SETTLE;
                        end
                        REQ_FAULT: begin
                            s_d.sample = 1'b0;
                            s_d.mode   = MODE_CFG;
                            tmr_load   = 1'b1;
                            tmr_val    = TMR_W'(RECOVER_CYC);
                            s_d.phase  = PH_SETTLE;
                        end
                        default: begin
                            s_d.vld  = 1'b1;
                            s_d.err  = 1'b1;
                            s_d.data = '0;
                        end
                    endcase
                end
            end

            PH_SETTLE: begin
                if (tmr_expired) begin
                    if (s_q.kind == REQ_FAULT) begin
                        s_d.sample = 1'b1;
                        s_d.tx     = FAULT_ADDR;
                        s_d.last   = 1'b1;
                    end else begin
                        s_d.tx     = READ_FILL;
                        s_d.last   = 1'b0;
                    end
                    s_d.start = 1'b1;
                    s_d.phase = PH_XFER;
                end
            end

            PH_XFER: begin
                if (spi_done) begin
                    if (!s_q.second) begin
                        s_d.hi_byte = spi_rx;
                        s_d.second  = 1'b1;
                        s_d.start   = 1'b1;
                        s_d.last    = 1'b1;
                        s_d.tx      = (s_q.kind == REQ_FAULT) ? FAULT_DUMMY : READ_FILL;
                    end else begin
                        s_d.word = {s_q.hi_byte, spi_rx};
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(RECOVER_CYC);
                        if (s_q.kind == REQ_FAULT) begin
                            s_d.sample = 1'b0;
                            s_d.phase  = PH_PULSE;
                        end else begin
                            s_d.sample = 1'b1;
                            s_d.phase  = PH_GUARD;
                        end
                    end
                end
            end

            PH_PULSE: begin
                if (tmr_expired) begin
                    s_d.sample = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TMR_W'(RECOVER_CYC);
                    s_d.phase  = PH_GUARD;
                end
            end

            PH_GUARD: begin
                if (tmr_expired) begin
                    s_d.vld   = 1'b1;
                    s_d.data  = aligned;
                    s_d.phase = PH_IDLE;
                end
            end

            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.phase   <= PH_IDLE;
            s_q.kind    <= REQ_ANGLE;
            s_q.sample  <= 1'b1;
            s_q.mode    <= MODE_CFG;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.phase == PH_IDLE);
    assign spi_start  = s_q.start;
    assign spi_tx     = s_q.tx;
    assign spi_last   = s_q.last;
    assign sample_pin = s_q.sample;
    assign mode_pins  = s_q.mode;
    assign res_pins   = s_q.rpins;
    assign rslt_valid = s_q.vld;
    assign rslt_err   = s_q.err;
    assign rslt_data  = s_q.data;

endmodule

// File: rtl/rdc_sample_ctrl_chk.sv
module rdc_sample_ctrl_chk
    import rdc_pkg::*;
#(
    parameter int CONV_CLK_CYC = 4,
    parameter int GUARD_CYC    = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       spi_start,
    input logic [7:0] spi_tx,
    input logic       spi_last,
    input logic       sample_pin,
    input logic [1:0] mode_pins,
    input logic [1:0] res_pins,
    input logic       rslt_valid,
    input logic       rslt_err
);

    localparam int SETTLE_CYC  = 6 * CONV_CLK_CYC + GUARD_CYC;
    localparam int RECOVER_CYC = 2 * CONV_CLK_CYC + GUARD_CYC;
    localparam int RUN_W       = $clog2(SETTLE_CYC + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] low_run, high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= RUN_W'(RECOVER_CYC);
        end else if (sample_pin) begin
            low_run  <= '0;
            high_run <= (high_run == RUN_MAX) ? high_run : high_run + 1'b1;
        end else begin
            high_run <= '0;
            low_run  <= (low_run == RUN_MAX) ? low_run : low_run + 1'b1;
        end
    end

    // R1
    idle_sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sample_pin);

    // R2
    settle_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_start && !sample_pin) |-> (low_run >= RUN_W'(SETTLE_CYC)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mode_pins));

    // R3
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |=> !spi_start);

    // R6
    recover_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_pin) && $past(req_ready)) |-> (high_run >= RUN_W'(RECOVER_CYC)));

    // R7
    fault_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_start && mode_pins == MODE_CFG) |-> (spi_tx == FAULT_DUMMY && spi_last));

    // R8
    res_pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(res_pins));

    // R9
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_err |-> rslt_valid);

endmodule

bind rdc_sample_ctrl rdc_sample_ctrl_chk #(
    .CONV_CLK_CYC (CONV_CLK_CYC),
    .GUARD_CYC    (GUARD_CYC)
) i_rdc_sample_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .spi_start  (spi_start),
    .spi_tx     (spi_tx),
    .spi_last   (spi_last),
    .sample_pin (sample_pin),
    .mode_pins  (mode_pins),
    .res_pins   (res_pins),
    .rslt_valid (rslt_valid),
    .rslt_err   (rslt_err)
);

// File: tb/test_rdc_sample_ctrl.sv
module test_rdc_sample_ctrl;

    localparam int CONV_CLK_CYC = 4;
    localparam int GUARD_CYC    = 2;
    localparam int SETTLE_CYC   = 6 * CONV_CLK_CYC + GUARD_CYC;
    localparam int RECOVER_CYC  = 2 * CONV_CLK_CYC + GUARD_CYC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_ready;
    logic [1:0]  res_sel = 2'd1;
    logic        hyst_en = 1'b1;
    logic        spi_start;
    logic [7:0]  spi_tx;
    logic        spi_last;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = 8'h00;
    logic        sample_pin;
    logic [1:0]  mode_pins;
    logic [1:0]  res_pins;
    logic        rslt_valid;
    logic        rslt_err;
    logic [15:0] rslt_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rdc_sample_ctrl #(
        .CONV_CLK_CYC (CONV_CLK_CYC),
        .GUARD_CYC    (GUARD_CYC)
    ) i_rdc_sample_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_ready  (req_ready),
        .res_sel    (res_sel),
        .hyst_en    (hyst_en),
        .spi_start  (spi_start),
        .spi_tx     (spi_tx),
        .spi_last   (spi_last),
        .spi_done   (spi_done),
        .spi_rx     (spi_rx),
        .sample_pin (sample_pin),
        .mode_pins  (mode_pins),
        .res_pins   (res_pins),
        .rslt_valid (rslt_valid),
        .rslt_err   (rslt_err),
        .rslt_data  (rslt_data)
    );

    // SPI byte slave model and pin monitor, all at the falling edge
    logic [7:0] resp [0:7];
    logic [7:0] tx_log [0:7];
    logic       last_log [0:7];
    int         low_at_start [0:7];
    int nlog = 0, falls = 0, low_run = 0, cyc = 0, rise_cyc = 0, vld_gap = 0, pend = 0;
    logic prev_sample = 1'b1;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!sample_pin) low_run++; else low_run = 0;
            if (prev_sample && !sample_pin) falls++;
            if (!prev_sample && sample_pin) rise_cyc = cyc;
            prev_sample = sample_pin;
            if (rslt_valid) vld_gap = cyc - rise_cyc;
            if (spi_done) spi_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    spi_rx   = resp[(nlog - 1) % 8];
                    spi_done = 1'b1;
                end
            end
            if (spi_start && nlog < 8) begin
                tx_log[nlog]       = spi_tx;
                last_log[nlog]     = spi_last;
                low_at_start[nlog] = low_run;
                nlog++;
                pend = 3;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
        end
    endtask

    task automatic issue(input logic [1:0] kind);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_result(output logic [15:0] data, output logic err);
        for (int i = 0; i < 3000; i++) begin
            if (rslt_valid) break;
            @(negedge clk);
        end
        chk(rslt_valid == 1'b1, "R6 result strobe seen", rslt_valid, 1);
        data = rslt_data;
        err  = rslt_err;
    endtask

    task automatic prep(input logic [1:0] code, input logic hy, input logic [7:0] b0, input logic [7:0] b1);
        res_sel = code;
        hyst_en = hy;
        resp[0] = b0;
        resp[1] = b1;
        nlog    = 0;
        falls   = 0;
    endtask

    function automatic logic [15:0] exp_angle(input logic [15:0] w, input logic [1:0] code, input logic hy);
        int sh = 16 - (10 + 2 * code);
        return hy ? (w >> sh) : w;
    endfunction

    function automatic logic [15:0] exp_speed(input logic [15:0] w, input logic [1:0] code);
        int sh = 16 - (10 + 2 * code);
        logic signed [15:0] s = $signed(w);
        return 16'(s >>> sh);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(sample_pin == 1'b1, "R1 sample high after reset", sample_pin, 1);
        chk(mode_pins == 2'b01, "R1 config mode after reset", mode_pins, 1);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rslt_valid == 1'b0, "R1 no result after reset", rslt_valid, 0);
        chk(res_pins == 2'b10, "R8 pins for 12-bit code", res_pins, 2);
        res_sel = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk(res_pins == 2'b01, "R8 pins for 14-bit code", res_pins, 1);
    endtask

    task automatic t_angle(input logic [1:0] code, input logic hy, input logic [15:0] w);
        logic [15:0] d;
        logic e;
        prep(code, hy, w[15:8], w[7:0]);
        issue(2'd0);
        wait_result(d, e);
        chk(d == exp_angle(w, code, hy), "R4 angle alignment", d, exp_angle(w, code, hy));
        chk(e == 1'b0, "R4 no error", e, 0);
        chk(nlog == 2, "R3 two bytes", nlog, 2);
        chk(tx_log[0] == 8'h00 && tx_log[1] == 8'h00, "R3 fill bytes", {tx_log[0], tx_log[1]}, 0);
        chk(last_log[0] == 1'b0 && last_log[1] == 1'b1, "R3 last flags", {last_log[0], last_log[1]}, 1);
        chk(low_at_start[0] >= SETTLE_CYC, "R2 settle low time", low_at_start[0], SETTLE_CYC);
        chk(mode_pins == 2'b00, "R2 angle mode pins", mode_pins, 0);
        chk(vld_gap >= RECOVER_CYC, "R6 recovery before result", vld_gap, RECOVER_CYC);
        chk(sample_pin == 1'b1, "R6 sample high at result", sample_pin, 1);
    endtask

    task automatic t_speed(input logic [1:0] code, input logic [15:0] w);
        logic [15:0] d;
        logic e;
        prep(code, 1'b0, w[15:8], w[7:0]);
        issue(2'd1);
        wait_result(d, e);
        chk(d == exp_speed(w, code), "R5 speed sign-extended", d, exp_speed(w, code));
        chk(mode_pins == 2'b10, "R2 speed mode pins", mode_pins, 2);
        chk(low_at_start[0] >= SETTLE_CYC, "R2 settle low time speed", low_at_start[0], SETTLE_CYC);
    endtask

    task automatic t_fault(input logic [7:0] fb);
        logic [15:0] d;
        logic e;
        prep(2'd1, 1'b1, 8'h3C, fb);
        issue(2'd2);
        wait_result(d, e);
        chk(d == {8'h00, fb}, "R7 fault byte result", d, {8'h00, fb});
        chk(e == 1'b0, "R7 no error", e, 0);
        chk(nlog == 2 && tx_log[0] == 8'hFF && tx_log[1] == 8'hFF, "R7 address and dummy bytes",
            {tx_log[0], tx_log[1]}, 16'hFFFF);
        chk(last_log[0] == 1'b1 && last_log[1] == 1'b1, "R7 chip select per byte",
            {last_log[0], last_log[1]}, 3);
        chk(low_at_start[0] == 0, "R7 sample high during read", low_at_start[0], 0);
        chk(falls == 2, "R7 two sample pulses", falls, 2);
        chk(mode_pins == 2'b01, "R7 config mode", mode_pins, 1);
    endtask

    task automatic t_bad();
        prep(2'd1, 1'b1, 8'h11, 8'h22);
        issue(2'd3);
        chk(rslt_valid == 1'b1, "R9 immediate completion", rslt_valid, 1);
        chk(rslt_err == 1'b1, "R9 error flag", rslt_err, 1);
        chk(rslt_data == 16'h0000, "R9 zero data", rslt_data, 0);
        repeat (20) @(negedge clk);
        chk(nlog == 0, "R9 no SPI byte", nlog, 0);
        chk(falls == 0 && sample_pin == 1'b1, "R9 sample untouched", falls, 0);
    endtask

    task automatic t_busy();
        logic [15:0] d;
        logic e;
        logic [1:0] pins_before;
        prep(2'd0, 1'b1, 8'hAB, 8'hCD);
        issue(2'd0);
        pins_before = res_pins;
        repeat (4) @(negedge clk);
        res_sel   = 2'd3;
        hyst_en   = 1'b0;
        req_kind  = 2'd1;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        chk(res_pins == pins_before, "R8 pins held while busy", res_pins, pins_before);
        wait_result(d, e);
        chk(d == exp_angle(16'hABCD, 2'd0, 1'b1), "R10 settings from acceptance", d,
            exp_angle(16'hABCD, 2'd0, 1'b1));
        repeat (60) @(negedge clk);
        chk(nlog == 2, "R10 busy request ignored", nlog, 2);
        chk(req_ready == 1'b1, "R10 idle afterwards", req_ready, 1);
    endtask

    task automatic t_back_to_back();
        logic [15:0] d;
        logic e;
        prep(2'd1, 1'b0, 8'h80, 8'h40);
        resp[2] = 8'h99;
        resp[3] = 8'hA5;
        issue(2'd1);
        for (int i = 0; i < 3000; i++) begin
            if (rslt_valid) break;
            @(negedge clk);
        end
        chk(req_ready == 1'b1, "R11 ready with result", req_ready, 1);
        chk(rslt_data == exp_speed(16'h8040, 2'd1), "R11 first result", rslt_data, exp_speed(16'h8040, 2'd1));
        req_valid = 1'b1;
        req_kind  = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 accepted in strobe cycle", req_ready, 0);
        wait_result(d, e);
        chk(d == 16'h00A5, "R11 second result", d, 16'h00A5);
        chk(vld_gap >= RECOVER_CYC, "R6 recovery on second", vld_gap, RECOVER_CYC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_angle(2'd3, 1'b1, 16'hABCD);
        t_angle(2'd0, 1'b1, 16'hABCD);
        t_angle(2'd1, 1'b0, 16'hABCD);
        t_angle(2'd2, 1'b1, 16'h1234);
        t_speed(2'd0, 16'h8040);
        t_speed(2'd3, 16'hFFFE);
        t_speed(2'd1, 16'h7FF0);
        t_speed(2'd2, 16'hC004);
        t_fault(8'h5A);
        t_bad();
        t_busy();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule